// File: doc/BRIEF.md
# Time-Slot Synchronous Transfer Interrupt Unit

This unit follows the bit position inside a TDM frame and tells a microcontroller when each of four channels may move its data. The data clock is divided by two to form a bit clock. A frame has 32 slots of 8 bit clocks each. A frame sync puts the position back to slot 0, bit 0. Each channel has its own slot select and delay polarity. A fixed number of bit clocks after the end of that slot, the channel raises a sticky transfer interrupt and becomes pending.

Software answers by writing 1 to the channel's bit in an 8-bit acknowledge register. Each channel can also enable overflow detection against a second slot select. If the channel is still pending when the position reaches that slot's deadline, a sticky overflow flag is set. All status bits clear together on a read strobe. One interrupt line combines every transfer flag with every enabled overflow flag.

Top module: `tssi_unit`

## Requirements
- R1: Out of reset, all transfer and overflow status bits are 0, `irq_o` is 0 and `ack_reg_o` reads 0x00.
- R2: With delay polarity 0, a channel's transfer status sets on the data-clock edge where the bit position becomes ((slot+1)*8 + 2) mod 256. The position is slot*8 + bit, and the position p is reached 2p edges after the edge that sampled the frame sync.
- R3: With delay polarity 1, the transfer status sets on the edge where the position becomes ((slot+1)*8 + 1) mod 256.
- R4: An enabled channel that is still pending sets its overflow status on the edge where the position becomes (ovf_slot*8 - 1) mod 256 for polarity 0, or ovf_slot*8 mod 256 for polarity 1. A channel whose overflow enable is 0 never sets its overflow status.
- R5: A write of 1 to acknowledge bit 0, 1, 2 or 3 (channels 10, 11, 20, 21) clears that channel's pending state. An acknowledge on the same edge as the deadline still counts as in time. Writing 0 to a bit has no effect.
- R6: An acknowledge written while the channel is not pending is ignored and does not pre-arm the next transfer interrupt.
- R7: An acknowledge that arrives after the overflow has fired clears the pending state, but the overflow status stays set.
- R8: `ack_reg_o` shows, for one cycle after a write, the acknowledge bits written to bits 3:0 and is 0x00 otherwise. Written bits 7:4 are ignored and always read 0.
- R9: Status bits are sticky. A read strobe clears all of them, and an event on the same edge wins over the clear.
- R10: `irq_o` is 1 exactly when some transfer status bit is set or some overflow status bit is set whose enable is 1.
- R11: A frame sync at any time restarts the position at slot 0, bit 0, and later events are timed from that edge.
- R12: The bit position advances once every two data-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, restarts the bit position |
| slot_sel_i | input | 20 | Transfer slot per channel, 5 bits each, channel 0 in the low bits |
| dly_pol_i | input | 4 | Delay polarity per channel |
| ovf_slot_i | input | 20 | Overflow deadline slot per channel, 5 bits each |
| ovf_en_i | input | 4 | Overflow detection enable per channel |
| ack_wr_i | input | 1 | Acknowledge register write strobe |
| ack_wdata_i | input | 8 | Acknowledge write data, bits 3:0 used |
| rd_clr_i | input | 1 | Status read strobe, clears all status |
| sti_o | output | 4 | Sticky transfer interrupt status |
| ovf_o | output | 4 | Sticky overflow status |
| irq_o | output | 1 | Combined interrupt |
| ack_reg_o | output | 8 | Acknowledge register read value |

## Verification
Directed runs first set all four channels to different slot, polarity and deadline values. They then probe the cycle on each side of every expected edge, so that a wrong polarity offset, a wrong divider phase or an off-by-one deadline shows up as a one-cycle shift. Separate patterns tell apart an acknowledge that is early and ignored, one that is in time on the deadline edge, one that is late, a zero write and a write to the upper bits only. A mid-run frame sync shows whether the position restarts. A long stretch of random configuration, acknowledge, read-clear and sync activity is then compared each cycle against a position-level model. This exercises wrap-around targets, deadlines in slot 0 and events that collide with clears.

// File: rtl/tssi_pkg.sv
package tssi_pkg;

  typedef struct packed {
    logic pend;
    logic sti;
    logic ovf;
  } ch_state_t;

  // bit position at which the transfer interrupt fires
  function automatic int unsigned sti_pos(int unsigned slot, logic pol,
                                          int unsigned slot_bits, int unsigned frame_len);
    return ((slot + 1) * slot_bits + (pol ? 1 : 2)) % frame_len;
  endfunction

  // bit position by which the acknowledge must have arrived
  function automatic int unsigned dl_pos(int unsigned slot, logic pol,
                                         int unsigned slot_bits, int unsigned frame_len);
    return (slot * slot_bits + frame_len - (pol ? 0 : 1)) % frame_len;
  endfunction

endpackage

// File: rtl/tssi_timebase.sv
module tssi_timebase #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned POS_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             phase_o,
  output logic             adv_o,
  output logic [POS_W-1:0] pos_nxt_o
);

  logic [POS_W-1:0] pos_q;
  logic             phase_q;

  assign pos_nxt_o = (pos_q == POS_W'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
  assign adv_o     = phase_q & ~fsync_i;
  assign pos_o     = pos_q;
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      phase_q <= 1'b0;
    end else if (fsync_i) begin
      pos_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) pos_q <= pos_nxt_o;
    end
  end

endmodule

// File: rtl/tssi_ack_port.sv
module tssi_ack_port #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_CH-1:0] ack_o,
  output logic [REG_W-1:0]  reg_o
);

  logic [NUM_CH-1:0] reg_q;

  assign ack_o = wr_i ? wdata_i[NUM_CH-1:0] : '0;

  generate
    if (REG_W > NUM_CH) begin : g_pad
      assign reg_o = {{(REG_W-NUM_CH){1'b0}}, reg_q};
    end else begin : g_nopad
      assign reg_o = reg_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= ack_o;
  end

endmodule

// File: rtl/tssi_chan.sv
module tssi_chan
  import tssi_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned POS_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [POS_W-1:0]  pos_nxt_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pol_i,
  input  logic [SLOT_W-1:0] oslot_i,
  input  logic              oen_i,
  input  logic              ack_i,
  input  logic              rd_clr_i,
  output logic              sti_o,
  output logic              ovf_o
);

  localparam int unsigned FRAME_LEN = SLOT_BITS * NUM_SLOTS;

  logic [POS_W-1:0] tgt, dl;
  logic             sti_ev, ovf_ev;
  ch_state_t        st_q, st_d;

  always_comb begin
    tgt = POS_W'(sti_pos(int'(slot_i), pol_i, SLOT_BITS, FRAME_LEN));
    dl  = POS_W'(dl_pos(int'(oslot_i), pol_i, SLOT_BITS, FRAME_LEN));
  end

  assign sti_ev = adv_i & (pos_nxt_i == tgt);
  // an acknowledge on the deadline edge is still in time
  assign ovf_ev = adv_i & (pos_nxt_i == dl) & oen_i & st_q.pend & ~ack_i;

  always_comb begin
    st_d.pend = sti_ev | (st_q.pend & ~ack_i);
    st_d.sti  = sti_ev | (st_q.sti  & ~rd_clr_i);
    st_d.ovf  = ovf_ev | (st_q.ovf  & ~rd_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign sti_o = st_q.sti;
  assign ovf_o = st_q.ovf;

endmodule

// File: rtl/tssi_unit.sv
module tssi_unit #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned POS_W     = $clog2(SLOT_BITS * NUM_SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fsync_i,
  input  logic [NUM_CH*SLOT_W-1:0] slot_sel_i,
  input  logic [NUM_CH-1:0]        dly_pol_i,
  input  logic [NUM_CH*SLOT_W-1:0] ovf_slot_i,
  input  logic [NUM_CH-1:0]        ovf_en_i,
  input  logic                     ack_wr_i,
  input  logic [REG_W-1:0]         ack_wdata_i,
  input  logic                     rd_clr_i,
  output logic [NUM_CH-1:0]        sti_o,
  output logic [NUM_CH-1:0]        ovf_o,
  output logic                     irq_o,
  output logic [REG_W-1:0]         ack_reg_o
);

  localparam int unsigned FRAME_LEN = SLOT_BITS * NUM_SLOTS;

  logic [POS_W-1:0]  pos_q, pos_nxt;
  logic              phase_q, adv;
  logic [NUM_CH-1:0] ack;

  tssi_timebase #(
    .FRAME_LEN(FRAME_LEN),
    .POS_W    (POS_W)
  ) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .pos_o    (pos_q),
    .phase_o  (phase_q),
    .adv_o    (adv),
    .pos_nxt_o(pos_nxt)
  );

  tssi_ack_port #(
    .NUM_CH(NUM_CH),
    .REG_W (REG_W)
  ) u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ack_wr_i),
    .wdata_i(ack_wdata_i),
    .ack_o  (ack),
    .reg_o  (ack_reg_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tssi_chan #(
      .SLOT_BITS(SLOT_BITS),
      .NUM_SLOTS(NUM_SLOTS),
      .SLOT_W   (SLOT_W),
      .POS_W    (POS_W)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .pos_nxt_i(pos_nxt),
      .slot_i   (slot_sel_i[c*SLOT_W +: SLOT_W]),
      .pol_i    (dly_pol_i[c]),
      .oslot_i  (ovf_slot_i[c*SLOT_W +: SLOT_W]),
      .oen_i    (ovf_en_i[c]),
      .ack_i    (ack[c]),
      .rd_clr_i (rd_clr_i),
      .sti_o    (sti_o[c]),
      .ovf_o    (ovf_o[c])
    );
  end

  assign irq_o = (|sti_o) | (|(ovf_o & ovf_en_i));

endmodule

// File: rtl/tssi_unit_chk.sv
module tssi_unit_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned POS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic              rd_clr_i,
  input logic [NUM_CH-1:0] ovf_en_i,
  input logic [NUM_CH-1:0] sti_o,
  input logic [NUM_CH-1:0] ovf_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  ack_reg_o,
  input logic [POS_W-1:0]  pos_q,
  input logic              phase_q
);

  assert_irq_on_sti_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sti_o) |-> irq_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> (((sti_o & $past(sti_o)) == $past(sti_o)) &&
                   ((ovf_o & $past(ovf_o)) == $past(ovf_o))));

  assert_no_ovf_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((ovf_o & ~$past(ovf_o) & ~$past(ovf_en_i)) == '0));

  assert_ack_hi_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_reg_o[REG_W-1:NUM_CH] == '0);

  assert_half_rate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && !phase_q) |=> $stable(pos_q));

  assert_fsync_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q == '0 && !phase_q));

endmodule

bind tssi_unit tssi_unit_chk #(
  .NUM_CH(NUM_CH),
  .REG_W (REG_W),
  .POS_W (POS_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fsync_i  (fsync_i),
  .rd_clr_i (rd_clr_i),
  .ovf_en_i (ovf_en_i),
  .sti_o    (sti_o),
  .ovf_o    (ovf_o),
  .irq_o    (irq_o),
  .ack_reg_o(ack_reg_o),
  .pos_q    (pos_q),
  .phase_q  (phase_q)
);

// File: tb/tssi_unit_tb.sv
`timescale 1ns/1ps
module tssi_unit_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync_i = 1'b0;
  logic [19:0] slot_sel_i, ovf_slot_i;
  logic [3:0]  dly_pol_i, ovf_en_i;
  logic        ack_wr_i = 1'b0;
  logic [7:0]  ack_wdata_i = '0;
  logic        rd_clr_i = 1'b0;
  logic [3:0]  sti_o, ovf_o;
  logic        irq_o;
  logic [7:0]  ack_reg_o;

  int          cf_slot[4], cf_oslot[4];
  logic [3:0]  cf_pol = '0, cf_en = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [3:0] m_pend = '0, m_sti = '0, m_ovf = '0;
  logic [7:0] m_ack = '0;
  int         m_pos = 0;
  bit         m_phase = 0;

  always #2.5 clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      slot_sel_i[c*5 +: 5] = 5'(cf_slot[c]);
      ovf_slot_i[c*5 +: 5] = 5'(cf_oslot[c]);
    end
    dly_pol_i = cf_pol;
    ovf_en_i  = cf_en;
  end

  tssi_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i),
    .slot_sel_i(slot_sel_i), .dly_pol_i(dly_pol_i),
    .ovf_slot_i(ovf_slot_i), .ovf_en_i(ovf_en_i),
    .ack_wr_i(ack_wr_i), .ack_wdata_i(ack_wdata_i), .rd_clr_i(rd_clr_i),
    .sti_o(sti_o), .ovf_o(ovf_o), .irq_o(irq_o), .ack_reg_o(ack_reg_o)
  );

  function automatic int tgt_f(int s, logic p);
    return ((s + 1) * 8 + (p ? 1 : 2)) % 256;
  endfunction

  function automatic int dl_f(int o, logic p);
    return (o * 8 + 256 - (p ? 0 : 1)) % 256;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit adv;
    int nxt;
    logic ack;
    logic [3:0] sti_ev, ovf_ev;
    adv = m_phase && !fsync_i;
    nxt = (m_pos + 1) % 256;
    for (int c = 0; c < 4; c++) begin
      ack = ack_wr_i && ack_wdata_i[c];
      sti_ev[c] = adv && (nxt == tgt_f(cf_slot[c], cf_pol[c]));
      ovf_ev[c] = adv && (nxt == dl_f(cf_oslot[c], cf_pol[c])) && cf_en[c] && m_pend[c] && !ack;
      m_pend[c] = sti_ev[c] | (m_pend[c] & !ack);
    end
    m_sti = sti_ev | (rd_clr_i ? 4'b0 : m_sti);
    m_ovf = ovf_ev | (rd_clr_i ? 4'b0 : m_ovf);
    m_ack = ack_wr_i ? {4'b0, ack_wdata_i[3:0]} : 8'h00;
    if (fsync_i) begin
      m_pos = 0; m_phase = 0;
    end else begin
      if (m_phase) m_pos = nxt;
      m_phase = !m_phase;
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    chk("R2 R3 sti", sti_o, m_sti);
    chk("R4 ovf", ovf_o, m_ovf);
    chk("R10 irq", irq_o, (|m_sti) | (|(m_ovf & cf_en)));
    chk("R8 ack_reg", ack_reg_o, m_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cf_slot  = '{0, 3, 1, 0};
    cf_pol   = 4'b1010;
    cf_oslot = '{2, 5, 3, 4};
    cf_en    = 4'b1101;
    repeat (3) @(negedge clk_i);
    chk("R1 sti", sti_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 ack_reg", ack_reg_o, 0);
    rst_ni = 1'b1;

    // directed: edge 0 samples the frame sync
    for (int i = 0; i <= 130; i++) begin
      fsync_i = 0; ack_wr_i = 0; ack_wdata_i = '0; rd_clr_i = 0;
      case (i)
        0:   fsync_i = 1;
        5:   begin ack_wr_i = 1; ack_wdata_i = 8'h04; end
        25:  begin ack_wr_i = 1; ack_wdata_i = 8'h00; end
        26:  begin ack_wr_i = 1; ack_wdata_i = 8'hF0; end
        40:  begin ack_wr_i = 1; ack_wdata_i = 8'h01; end
        45:  rd_clr_i = 1;
        64:  begin ack_wr_i = 1; ack_wdata_i = 8'h08; end
        100: begin fsync_i = 1; rd_clr_i = 1; end
        default: ;
      endcase
      step();
      case (i)
        19:  chk("R12 sti0 not yet", sti_o[0], 0);
        20:  begin chk("R2 sti0", sti_o[0], 1); chk("R10 irq", irq_o, 1); end
        26:  chk("R8 upper bits", ack_reg_o, 0);
        29:  chk("R4 ovf0 not yet", ovf_o[0], 0);
        30:  chk("R4 ovf0 (R5 zero write)", ovf_o[0], 1);
        41:  chk("R7 ovf0 after late ack", ovf_o[0], 1);
        45:  begin
               chk("R9 sti cleared", sti_o, 0);
               chk("R9 ovf cleared", ovf_o, 0);
               chk("R10 irq low", irq_o, 0);
             end
        46:  chk("R6 ovf2 no pre-arm", ovf_o[2], 1);
        64:  chk("R8 ack_reg", ack_reg_o, 8'h08);
        65:  begin chk("R8 ack_reg cleared", ack_reg_o, 0); chk("R3 sti1 not yet", sti_o[1], 0); end
        66:  begin chk("R3 sti1", sti_o[1], 1); chk("R5 ovf3 in time", ovf_o[3], 0); end
        82:  chk("R4 ovf1 disabled", ovf_o[1], 0);
        119: chk("R11 sti0 not yet", sti_o[0], 0);
        120: chk("R11 sti0 after resync", sti_o[0], 1);
        default: ;
      endcase
    end

    // random phase
    for (int n = 0; n < 6000; n++) begin
      fsync_i = 0; ack_wr_i = 0; ack_wdata_i = '0; rd_clr_i = 0;
      if (n % 400 == 0) begin
        for (int c = 0; c < 4; c++) begin
          cf_slot[c]  = int'($urandom % 32);
          cf_oslot[c] = int'($urandom % 32);
        end
        cf_pol = 4'($urandom);
        cf_en  = 4'($urandom);
      end
      fsync_i  = ($urandom % 600) == 0;
      ack_wr_i = ($urandom % 10) == 0;
      ack_wdata_i = 8'($urandom);
      rd_clr_i = ($urandom % 20) == 0;
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule